// File: doc/BRIEF.md
# Mode-Selectable Burst Address Sequencer

This block produces the low offset bits of a four-beat burst for a synchronous burst memory controller. When the controller accepts an address strobe, it pulses a load input with the low bits of the external address, and the sequencer presents that value as the first beat. Each advance request then moves the offset to the next beat of the burst. A cycle with neither a load nor an advance is a wait cycle, and the offset holds.

A static strap input selects the order of the beats. In interleaved order the offset is the start value XOR a running beat count. In linear order the offset is the start value plus the beat count, wrapped within the aligned block. After the last beat the sequence returns to the start offset and carries on. An optional flag marks the last beat of each pass. The parent controller keeps the upper address bits. Arbitration between strobes and chip-select decoding belong to the parent.

Top module: `bseq_top`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, ofs_o is 0 and last_o is 0.
- R2: A load_i sampled high at a rising edge makes ofs_o equal the sampled start_i and clears last_o from that edge on.
- R3: When load_i and adv_i are both high at the same edge, the load wins. ofs_o becomes start_i, and the next advance moves to the second beat.
- R4: An edge with load_i and adv_i both low leaves ofs_o and last_o unchanged.
- R5: With mode_ilv_i = 0 (linear), each advance adds 1 to ofs_o modulo 4. The bursts are 0,1,2,3 / 1,2,3,0 / 2,3,0,1 / 3,0,1,2 for starts 0 to 3.
- R6: With mode_ilv_i = 1 (interleaved), ofs_o after k advances is start XOR (k mod 4). The bursts are 0,1,2,3 / 1,0,3,2 / 2,3,0,1 / 3,2,1,0.
- R7: The advance after the fourth beat returns ofs_o to the start offset, and the sequence repeats without stopping.
- R8: With LAST_EN = 1, last_o is high exactly on the fourth beat of each pass, that is, after 3, 7, ... advances since the load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Address strobe accepted: load start_i |
| start_i | input | OFS_W | Low external address bits |
| adv_i | input | 1 | Advance to the next beat |
| mode_ilv_i | input | 1 | Static order strap: 1 interleaved, 0 linear |
| ofs_o | output | OFS_W | Current beat offset |
| last_o | output | 1 | Last beat of the current pass |

## Verification
The bench builds the block with its defaults, OFS_W = 2 and LAST_EN = 1. With these values all four start offsets in both orders can be walked through two full passes, so the wrap back to the start and the last-beat flag are seen twice per burst. Wait cycles are placed mid-burst. A load is given together with an advance in the middle of a burst. A reset is applied mid-burst. Each of these cases lands on a known beat count.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  localparam int MAXW = 8;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  function automatic logic [MAXW-1:0] wmask(input int unsigned w);
    return MAXW'((1 << w) - 1);
  endfunction

  function automatic logic [MAXW-1:0] lin_ofs(input logic [MAXW-1:0] s,
                                               input logic [MAXW-1:0] b,
                                               input int unsigned w);
    return (s + b) & wmask(w);
  endfunction

  function automatic logic [MAXW-1:0] ilv_ofs(input logic [MAXW-1:0] s,
                                               input logic [MAXW-1:0] b,
                                               input int unsigned w);
    return (s ^ b) & wmask(w);
  endfunction

endpackage

// File: rtl/bseq_anchor.sv
module bseq_anchor #(
  parameter int OFS_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [OFS_W-1:0] start_i,
  output logic [OFS_W-1:0] start_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      start_q <= '0;
    else if (load_i) start_q <= start_i;
  end
endmodule

// File: rtl/bseq_beat.sv
module bseq_beat #(
  parameter int OFS_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             adv_i,
  output logic [OFS_W-1:0] beat_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      beat_q <= '0;
    else if (load_i) beat_q <= '0;
    else if (adv_i)  beat_q <= beat_q + 1'b1;
  end
endmodule

// File: rtl/bseq_map.sv
module bseq_map
  import bseq_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  logic [OFS_W-1:0] start_q,
  input  logic [OFS_W-1:0] beat_q,
  input  logic             mode_ilv_i,
  output logic [OFS_W-1:0] ofs_o
);
  logic [MAXW-1:0] s_ext, b_ext, lin_v, ilv_v;
  order_e          order;

  always_comb begin
    s_ext = MAXW'(start_q);
    b_ext = MAXW'(beat_q);
    lin_v = lin_ofs(s_ext, b_ext, OFS_W);
    ilv_v = ilv_ofs(s_ext, b_ext, OFS_W);
    order = order_e'(mode_ilv_i);
    ofs_o = (order == ORD_INTERLEAVE) ? ilv_v[OFS_W-1:0] : lin_v[OFS_W-1:0];
  end
endmodule

// File: rtl/bseq_top.sv
module bseq_top #(
  parameter int OFS_W   = 2,
  parameter bit LAST_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [OFS_W-1:0] start_i,
  input  logic             adv_i,
  input  logic             mode_ilv_i,
  output logic [OFS_W-1:0] ofs_o,
  output logic             last_o
);
  localparam logic [OFS_W-1:0] LAST_BEAT = {OFS_W{1'b1}};

  logic [OFS_W-1:0] start_q;
  logic [OFS_W-1:0] beat_q;
  logic             step_evt;

  assign step_evt = adv_i & ~load_i;

  bseq_anchor #(.OFS_W(OFS_W)) i_anchor (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_i(start_i), .start_q(start_q)
  );

  bseq_beat #(.OFS_W(OFS_W)) i_beat (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .adv_i(adv_i), .beat_q(beat_q)
  );

  bseq_map #(.OFS_W(OFS_W)) i_map (
    .start_q(start_q), .beat_q(beat_q), .mode_ilv_i(mode_ilv_i), .ofs_o(ofs_o)
  );

  generate
    if (LAST_EN) begin : g_last
      assign last_o = (beat_q == LAST_BEAT);
    end else begin : g_nolast
      assign last_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/bseq_chk.sv
module bseq_chk #(
  parameter int OFS_W   = 2,
  parameter bit LAST_EN = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_i,
  input logic [OFS_W-1:0] start_i,
  input logic             adv_i,
  input logic             mode_ilv_i,
  input logic [OFS_W-1:0] ofs_o,
  input logic             last_o,
  input logic [OFS_W-1:0] start_q,
  input logic [OFS_W-1:0] beat_q,
  input logic             step_evt
);
  localparam logic [OFS_W-1:0] LAST_BEAT = {OFS_W{1'b1}};

  // R2
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (ofs_o == $past(start_i)) && !last_o);

  // R3
  prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && adv_i) |=> (beat_q == '0));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_i) |=> ($stable(ofs_o) && $stable(last_o)) || !$stable(mode_ilv_i));

  // R5
  lin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !mode_ilv_i) |=> (ofs_o == $past(ofs_o) + 1'b1) || !$stable(mode_ilv_i));

  // R6
  ilv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && mode_ilv_i) |=>
      ((ofs_o ^ $past(ofs_o)) == (beat_q ^ $past(beat_q))) || !$stable(mode_ilv_i));

  // R7
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && beat_q == LAST_BEAT) |=> (ofs_o == start_q));

  // R8
  last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(last_o) |-> (LAST_EN && $past(step_evt)));
endmodule

bind bseq_top bseq_chk #(.OFS_W(OFS_W), .LAST_EN(LAST_EN)) i_chk (
  .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_i(start_i), .adv_i(adv_i),
  .mode_ilv_i(mode_ilv_i), .ofs_o(ofs_o), .last_o(last_o), .start_q(start_q),
  .beat_q(beat_q), .step_evt(step_evt)
);

// File: tb/test_bseq_top.sv
module test_bseq_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_i = 1'b0;
  logic [1:0] start_i = 2'd0;
  logic       adv_i = 1'b0;
  logic       mode_ilv_i = 1'b1;
  logic [1:0] ofs_o;
  logic       last_o;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  bseq_top i_bseq_top (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_i(start_i), .adv_i(adv_i),
    .mode_ilv_i(mode_ilv_i), .ofs_o(ofs_o), .last_o(last_o)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int want(input bit ilv, input int s, input int k);
    if (ilv) return s ^ (k % 4);
    return (s + k) % 4;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; load_i = 0; adv_i = 0;
    tick(); tick();
    chk("R1 ofs in reset", ofs_o, 0);
    chk("R1 last in reset", last_o, 0);
    rst_n = 1'b1;
    tick();
    chk("R1 ofs after release", ofs_o, 0);
    chk("R1 last after release", last_o, 0);
  endtask

  task automatic t_burst(input bit ilv, input int s);
    string rq;
    rq = ilv ? "R6" : "R5";
    mode_ilv_i = ilv; load_i = 1; adv_i = 0; start_i = 2'(s);
    tick();
    load_i = 0;
    chk("R2 load start", ofs_o, s);
    chk("R2 last cleared", last_o, 0);
    for (int k = 1; k <= 8; k++) begin
      if (k == 3) begin
        adv_i = 0;
        tick();
        chk("R4 wait holds ofs", ofs_o, want(ilv, s, 2));
        chk("R4 wait holds last", last_o, 0);
      end
      adv_i = 1;
      tick();
      chk(k >= 4 ? "R7 wrap" : rq, ofs_o, want(ilv, s, k));
      chk("R8 last beat", last_o, int'((k % 4) == 3));
    end
    adv_i = 0;
  endtask

  task automatic t_priority(input bit ilv);
    mode_ilv_i = ilv; load_i = 1; start_i = 2'd1; adv_i = 0;
    tick();
    load_i = 0; adv_i = 1;
    tick(); tick();
    load_i = 1; adv_i = 1; start_i = 2'd2;
    tick();
    chk("R3 load wins", ofs_o, 2);
    chk("R3 last low", last_o, 0);
    load_i = 0;
    tick();
    chk("R3 second beat", ofs_o, want(ilv, 2, 1));
    adv_i = 0;
  endtask

  task automatic t_mid_reset();
    mode_ilv_i = 1; load_i = 1; start_i = 2'd3; adv_i = 0;
    tick();
    load_i = 0; adv_i = 1;
    tick();
    rst_n = 0; adv_i = 0;
    tick();
    chk("R1 mid-burst reset", ofs_o, 0);
    rst_n = 1;
    tick();
    chk("R1 after mid reset", ofs_o, 0);
  endtask

  initial begin
    t_reset();
    for (int s = 0; s < 4; s++) t_burst(1'b0, s);
    for (int s = 0; s < 4; s++) t_burst(1'b1, s);
    t_priority(1'b0);
    t_priority(1'b1);
    t_mid_reset();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule